// File: doc/BRIEF.md
# Dual-Port Memory with Same-Address Arbitration

This block is a 4096-bit storage array with two synchronous ports, A and B. Each port can read or write in every cycle, and the two ports may work at the same moment. A parameter shared by both ports sets the word width to 1, 2, 4 or 8 bits, so the depth is 4096, 2048, 1024 or 512 words. Both ports sample their requests on the rising edge of one common clock. Each port has its own optional output register, and that register can capture on the rising edge or on the falling edge.

When both ports name the same word in the same cycle, the active-low flag `match_n` goes low. A fixed rule resolves the conflict. A write beats a read. When the two writes collide, port A wins and port B's write is held in a one-entry pending slot and lands one cycle later. A port that reads the word while the other port writes it first returns the old word. If that port then stays idle for one cycle, its output changes to the newly written word.

A parameter puts the block into a read-only mode. In that mode every write request is dropped and the contents are only the start-up pattern. The start-up pattern of word `i` is `(i * INIT_STEP + INIT_BASE) mod 2^DW`, in both modes.

Top module: `dpr_mem`

## Requirements
- R1: With `DW` in {1,2,4,8} the depth is 4096/DW words and the address width is log2 of the depth. Before any write, word `i` reads as `(i*INIT_STEP + INIT_BASE) mod 2^DW`. Each port reads its own address independently of the other port.
- R2: A read issued at a rising edge shows on the port's read data just after that edge. When the port's output register is enabled, it shows one register stage later.
- R3: A port that writes, or that is idle, keeps its read data unchanged. The only exception is the refresh of R6/R7.
- R4: When both ports read the same address in the same cycle, both return the stored word.
- R5: `match_n` is 0 while both ports are enabled and their addresses are equal. Otherwise it is 1. It follows the inputs within the same cycle.
- R6: When A writes and B reads the same address, B first returns the old word. If B is idle in the next cycle, its read data then changes to A's word.
- R7: When A reads and B writes the same address, A first returns the old word. If A is idle in the next cycle, its read data then changes to B's word.
- R8: When both ports write the same address, A's word is stored at that edge and B's write is deferred. `b_busy` is 1 for exactly the following cycle, after which the word holds B's data. Writes to different addresses never raise `b_busy`.
- R9: With `ROM=1` all write requests are ignored and `b_busy` stays 0. Reads return the start-up pattern.
- R10: With the port's output register enabled and its clock-invert parameter set to 1, the read data updates at the falling edge that follows the sampling rising edge, and not before it.
- R11: During and after reset, and until the first read, both read data outputs are 0 and `b_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock; requests sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of control and read registers |
| a_en | input | 1 | Port A access request |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_addr | input | AW | Port A word address |
| a_wdata | input | DW | Port A write word |
| a_rdata | output | DW | Port A read word |
| b_en | input | 1 | Port B access request |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_addr | input | AW | Port B word address |
| b_wdata | input | DW | Port B write word |
| b_rdata | output | DW | Port B read word |
| b_busy | output | 1 | Port B write is pending after a write-write collision |
| match_n | output | 1 | Low when both ports address the same word |

## Verification
The bench sweeps every address of a 4-bit-wide build on both ports in opposite directions. A swapped address path or a wrong start-up formula therefore shows as a mismatch on some word. It then drives each of the four collision kinds on a chosen word. A design that let the reader see the new word at once, that never refreshed, or that let B win a write-write collision would return the wrong value in the first or the second cycle. A design that forgot the pending write would leave `b_busy` low. A second, read-only build with a falling-edge output stage checks that forced writes change nothing. In that build, data that appears at the rising edge, or only one full cycle late, fails the half-cycle samples.

// File: rtl/dpr_pkg.sv
// Package: shared constants, the start-up content formula and the
// per-port control record passed from the arbiter to the array.
// Assumes: word width is a power of two that divides the capacity.
package dpr_pkg;

    localparam int TOTAL_BITS = 4096;

    // Per-port decoded request after arbitration.
    typedef struct packed {
        logic idle;     // port issues nothing this cycle
        logic rd;       // port reads this cycle
        logic wr;       // port writes into the array at this edge
        logic refresh;  // port must re-read its word next idle cycle
    } port_ctl_t;

    // Start-up content of word idx for a given width.
    function automatic int unsigned init_word(input int unsigned idx,
                                              input int unsigned step,
                                              input int unsigned base,
                                              input int unsigned dw);
        int unsigned raw;
        raw = idx * step + base;
        return raw & ((32'd1 << dw) - 32'd1);
    endfunction

endpackage

// File: rtl/dpr_arbiter.sv
// Module: same-address detector and fixed-priority resolver.
// Decodes each port's request and decides who writes now, whether
// port B's write is deferred and which reader needs a refresh.
// Assumes: both ports sample on the same rising clock edge.
module dpr_arbiter
    import dpr_pkg::*;
#(
    parameter int AW  = 9,
    parameter bit ROM = 1'b0
) (
    input  logic          a_en,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic          b_en,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    output port_ctl_t     ctl_a,
    output port_ctl_t     ctl_b,
    output logic          b_defer,
    output logic          match_n
);

    logic hit;
    logic a_wr_req;
    logic b_wr_req;
    logic a_rd_req;
    logic b_rd_req;

    // Decode raw requests; read-only mode drops every write.
    always_comb begin
        hit      = a_en && b_en && (a_addr == b_addr);
        a_wr_req = a_en && a_we && !ROM;
        b_wr_req = b_en && b_we && !ROM;
        a_rd_req = a_en && !a_we;
        b_rd_req = b_en && !b_we;
    end

    // Apply the priority rules: writes beat reads, A beats B.
    always_comb begin
        b_defer       = hit && a_wr_req && b_wr_req;

        ctl_a.idle    = !a_en;
        ctl_a.rd      = a_rd_req;
        ctl_a.wr      = a_wr_req;
        ctl_a.refresh = hit && a_rd_req && b_wr_req;

        ctl_b.idle    = !b_en;
        ctl_b.rd      = b_rd_req;
        ctl_b.wr      = b_wr_req && !b_defer;
        ctl_b.refresh = hit && b_rd_req && a_wr_req;

        match_n       = !hit;
    end

endmodule

// File: rtl/dpr_array.sv
// Module: the storage array, the pending slot for a deferred port B
// write, and one read-first read register per port with refresh.
// Assumes: DEPTH = 2**AW; writes at one edge land in the order
// pending B, direct B, A, so A has the last word on equal addresses.
module dpr_array
    import dpr_pkg::*;
#(
    parameter int          DW        = 8,
    parameter int          AW        = 9,
    parameter int unsigned INIT_STEP = 1,
    parameter int unsigned INIT_BASE = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    input  port_ctl_t     ctl_a,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    input  port_ctl_t     ctl_b,
    input  logic          b_defer,
    output logic [DW-1:0] a_raw,
    output logic [DW-1:0] b_raw,
    output logic          b_pend
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    logic [AW-1:0] pend_addr;
    logic [DW-1:0] pend_data;
    logic          pend_v;

    logic [AW-1:0] hold_a;
    logic [AW-1:0] hold_b;
    logic          ref_a_q;
    logic          ref_b_q;

    // Load the start-up pattern into every word.
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = DW'(init_word(i, INIT_STEP, INIT_BASE, DW));
        end
    end

    // Commit writes; A is applied last so it wins on equal addresses.
    always_ff @(posedge clk) begin
        if (pend_v) begin
            mem[pend_addr] <= pend_data;
        end
        if (ctl_b.wr) begin
            mem[b_addr] <= b_wdata;
        end
        if (ctl_a.wr) begin
            mem[a_addr] <= a_wdata;
        end
    end

    // Hold a port B write that lost a write-write collision.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_addr <= '0;
            pend_data <= '0;
        end else begin
            pend_v <= b_defer;
            if (b_defer) begin
                pend_addr <= b_addr;
                pend_data <= b_wdata;
            end
        end
    end

    // Port A read register: read-first, refreshed after a collision.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_raw   <= '0;
            hold_a  <= '0;
            ref_a_q <= 1'b0;
        end else begin
            ref_a_q <= ctl_a.refresh;
            if (ctl_a.rd) begin
                a_raw  <= mem[a_addr];
                hold_a <= a_addr;
            end else if (ctl_a.idle && ref_a_q) begin
                a_raw <= mem[hold_a];
            end
        end
    end

    // Port B read register: read-first, refreshed after a collision.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_raw   <= '0;
            hold_b  <= '0;
            ref_b_q <= 1'b0;
        end else begin
            ref_b_q <= ctl_b.refresh;
            if (ctl_b.rd) begin
                b_raw  <= mem[b_addr];
                hold_b <= b_addr;
            end else if (ctl_b.idle && ref_b_q) begin
                b_raw <= mem[hold_b];
            end
        end
    end

    assign b_pend = pend_v;

endmodule

// File: rtl/dpr_outstage.sv
// Module: optional output register for one port with a selectable
// capture edge. When disabled, the raw read word passes straight out.
// Assumes: reset is asynchronous and active low on either edge choice.
module dpr_outstage #(
    parameter int DW  = 8,
    parameter bit EN  = 1'b0,
    parameter bit INV = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);

    logic [DW-1:0] r;

    generate
        if (INV) begin : g_fall
            // Capture on the falling edge of the common clock.
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    r <= '0;
                end else begin
                    r <= d;
                end
            end
        end else begin : g_rise
            // Capture on the rising edge of the common clock.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    r <= '0;
                end else begin
                    r <= d;
                end
            end
        end
    endgenerate

    // Select registered or direct read data.
    assign q = EN ? r : d;

endmodule

// File: rtl/dpr_mem.sv
// Module: top of the dual-port memory. Ties together the arbiter, the
// array and one output stage per port.
// Assumes: DW is 1, 2, 4 or 8; both ports share clk.
module dpr_mem
    import dpr_pkg::*;
#(
    parameter int          DW         = 8,
    parameter bit          ROM        = 1'b0,
    parameter bit          OUT_REG_A  = 1'b0,
    parameter bit          OUT_REG_B  = 1'b0,
    parameter bit          CLK_INV_A  = 1'b0,
    parameter bit          CLK_INV_B  = 1'b0,
    parameter int unsigned INIT_STEP  = 1,
    parameter int unsigned INIT_BASE  = 0,
    localparam int         DEPTH      = TOTAL_BITS / DW,
    localparam int         AW         = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_en,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_en,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata,
    output logic          b_busy,
    output logic          match_n
);

    port_ctl_t     ctl_a;
    port_ctl_t     ctl_b;
    logic          b_defer;
    logic [DW-1:0] a_raw;
    logic [DW-1:0] b_raw;

    dpr_arbiter #(
        .AW  (AW),
        .ROM (ROM)
    ) arb_i (
        .a_en    (a_en),
        .a_we    (a_we),
        .a_addr  (a_addr),
        .b_en    (b_en),
        .b_we    (b_we),
        .b_addr  (b_addr),
        .ctl_a   (ctl_a),
        .ctl_b   (ctl_b),
        .b_defer (b_defer),
        .match_n (match_n)
    );

    dpr_array #(
        .DW        (DW),
        .AW        (AW),
        .INIT_STEP (INIT_STEP),
        .INIT_BASE (INIT_BASE)
    ) arr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_addr  (a_addr),
        .a_wdata (a_wdata),
        .ctl_a   (ctl_a),
        .b_addr  (b_addr),
        .b_wdata (b_wdata),
        .ctl_b   (ctl_b),
        .b_defer (b_defer),
        .a_raw   (a_raw),
        .b_raw   (b_raw),
        .b_pend  (b_busy)
    );

    dpr_outstage #(
        .DW  (DW),
        .EN  (OUT_REG_A),
        .INV (CLK_INV_A)
    ) out_a_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (a_raw),
        .q     (a_rdata)
    );

    dpr_outstage #(
        .DW  (DW),
        .EN  (OUT_REG_B),
        .INV (CLK_INV_B)
    ) out_b_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (b_raw),
        .q     (b_rdata)
    );

endmodule

// File: rtl/dpr_mem_chk.sv
// Module: assertion checker for dpr_mem, attached by bind below.
// Observes the top ports and the raw per-port read words.
module dpr_mem_chk #(
    parameter int DW  = 8,
    parameter int AW  = 9,
    parameter bit ROM = 1'b0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          a_en,
    input logic          a_we,
    input logic [AW-1:0] a_addr,
    input logic [DW-1:0] a_wdata,
    input logic [DW-1:0] a_raw,
    input logic          b_en,
    input logic          b_we,
    input logic [AW-1:0] b_addr,
    input logic [DW-1:0] b_wdata,
    input logic [DW-1:0] b_raw,
    input logic          b_busy,
    input logic          match_n
);

    // R5: a low match flag needs both ports enabled
    a_r5_match_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        !match_n |-> (a_en && b_en));

    // R8: a write-write collision leaves B pending next cycle
    a_r8_busy_after_ww: assert property (@(posedge clk) disable iff (!rst_n)
        (!ROM && a_en && a_we && b_en && b_we && a_addr == b_addr) |=> b_busy);

    // R8: pending is only ever caused by a write-write collision
    a_r8_busy_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        b_busy |-> $past(a_en && a_we && b_en && b_we && a_addr == b_addr));

    // R9: read-only mode never defers a write
    a_r9_rom_never_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ROM |-> !b_busy);

    // R3: a writing port keeps its read word
    a_r3_a_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && a_we) |=> $stable(a_raw));

    // R3: a writing port keeps its read word
    a_r3_b_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (b_en && b_we) |=> $stable(b_raw));

    // R7: A reader sees B's word after one idle cycle
    a_r7_a_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        (!ROM && a_en && !a_we && b_en && b_we && a_addr == b_addr) ##1 !a_en
        |=> (a_raw == $past(b_wdata, 2)));

    // R6: B reader sees A's word after one idle cycle
    a_r6_b_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        (!ROM && b_en && !b_we && a_en && a_we && a_addr == b_addr) ##1 !b_en
        |=> (b_raw == $past(a_wdata, 2)));

endmodule

bind dpr_mem dpr_mem_chk #(
    .DW  (DW),
    .AW  (AW),
    .ROM (ROM)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_en    (a_en),
    .a_we    (a_we),
    .a_addr  (a_addr),
    .a_wdata (a_wdata),
    .a_raw   (a_raw),
    .b_en    (b_en),
    .b_we    (b_we),
    .b_addr  (b_addr),
    .b_wdata (b_wdata),
    .b_raw   (b_raw),
    .b_busy  (b_busy),
    .match_n (match_n)
);

// File: tb/dpr_mem_tb_top.sv
// Bench: read/write sweeps of a 4-bit build plus collision cases, and a
// read-only 2-bit build with a falling-edge output stage on port B.
module dpr_mem_tb_top;

    localparam int D  = 1024;
    localparam int RD = 2048;

    logic clk = 1'b0;
    logic rst_n;
    always #5 clk = ~clk;

    // Main build: 4-bit words, port B registered on the rising edge.
    logic       a_en, a_we, b_en, b_we;
    logic [9:0] a_addr, b_addr;
    logic [3:0] a_wdata, b_wdata, a_rdata, b_rdata;
    logic       b_busy, match_n;

    // Read-only build: 2-bit words, port B registered on the falling edge.
    logic        r_a_en, r_a_we, r_b_en, r_b_we;
    logic [10:0] r_a_addr, r_b_addr;
    logic [1:0]  r_a_wdata, r_b_wdata, r_a_rdata, r_b_rdata;
    logic        r_b_busy, r_match_n;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    int model [D];

    dpr_mem #(
        .DW(4), .ROM(1'b0), .OUT_REG_A(1'b0), .OUT_REG_B(1'b1),
        .CLK_INV_A(1'b0), .CLK_INV_B(1'b0), .INIT_STEP(3), .INIT_BASE(5)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
        .b_busy(b_busy), .match_n(match_n)
    );

    dpr_mem #(
        .DW(2), .ROM(1'b1), .OUT_REG_A(1'b0), .OUT_REG_B(1'b1),
        .CLK_INV_A(1'b0), .CLK_INV_B(1'b1), .INIT_STEP(7), .INIT_BASE(1)
    ) dut_rom_i (
        .clk(clk), .rst_n(rst_n),
        .a_en(r_a_en), .a_we(r_a_we), .a_addr(r_a_addr), .a_wdata(r_a_wdata), .a_rdata(r_a_rdata),
        .b_en(r_b_en), .b_we(r_b_we), .b_addr(r_b_addr), .b_wdata(r_b_wdata), .b_rdata(r_b_rdata),
        .b_busy(r_b_busy), .match_n(r_match_n)
    );

    function automatic int init_main(input int i);
        return (3 * i + 5) % 16;
    endfunction

    function automatic int init_rom(input int i);
        return (7 * i + 1) % 4;
    endfunction

    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_main;
        a_en = 1'b0; a_we = 1'b0; b_en = 1'b0; b_we = 1'b0;
    endtask

    // Both ports sweep all words in opposite order; B lags by one stage.
    task automatic sweep_read(input string req);
        for (int i = 0; i < D; i++) begin
            a_en = 1'b1; a_we = 1'b0; a_addr = 10'(i);
            b_en = 1'b1; b_we = 1'b0; b_addr = 10'(D - 1 - i);
            #1;
            chk("R5 distinct addresses", int'(match_n), 1);
            tick;
            chk(req, int'(a_rdata), model[i]);
            if (i > 0) chk(req, int'(b_rdata), model[D - i]);
        end
        idle_main;
        tick;
        chk(req, int'(b_rdata), model[0]);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int old, nw, da, db, prev;
        rst_n = 1'b0;
        idle_main;
        a_addr = '0; b_addr = '0; a_wdata = '0; b_wdata = '0;
        r_a_en = 1'b0; r_a_we = 1'b0; r_b_en = 1'b0; r_b_we = 1'b0;
        r_a_addr = '0; r_b_addr = '0; r_a_wdata = '0; r_b_wdata = '0;
        repeat (3) tick;

        // R11: reset state
        chk("R11 a_rdata in reset", int'(a_rdata), 0);
        chk("R11 b_rdata in reset", int'(b_rdata), 0);
        chk("R11 b_busy in reset", int'(b_busy), 0);
        rst_n = 1'b1;
        tick;
        chk("R11 a_rdata after reset", int'(a_rdata), 0);
        chk("R11 b_rdata after reset", int'(b_rdata), 0);
        chk("R11 b_busy after reset", int'(b_busy), 0);
        chk("R5 idle match_n", int'(match_n), 1);
        chk("R11 rom b_rdata after reset", int'(r_b_rdata), 0);

        // R1: start-up pattern on every word through both ports
        for (int i = 0; i < D; i++) model[i] = init_main(i);
        sweep_read("R1 start-up read");

        // R2: registered port B shows a read one stage late
        b_en = 1'b1; b_we = 1'b0; b_addr = 10'd7;
        tick;
        idle_main;
        chk("R2 b before output stage", int'(b_rdata), model[0]);
        tick;
        chk("R2 b after output stage", int'(b_rdata), model[7]);

        // R3: port A writes every word; its read data must not move
        prev = int'(a_rdata);
        for (int i = 0; i < D; i++) begin
            a_en = 1'b1; a_we = 1'b1; a_addr = 10'(i); a_wdata = 4'((i * 5 + 2) % 16);
            model[i] = (i * 5 + 2) % 16;
            tick;
            chk("R3 a_rdata held while writing", int'(a_rdata), prev);
        end
        idle_main;
        // Port B writes the even words
        prev = int'(b_rdata);
        for (int k = 0; k < D / 2; k++) begin
            b_en = 1'b1; b_we = 1'b1; b_addr = 10'(2 * k); b_wdata = 4'((k * 9 + 1) % 16);
            model[2 * k] = (k * 9 + 1) % 16;
            tick;
        end
        idle_main;
        tick;
        chk("R3 b_rdata held while writing", int'(b_rdata), prev);
        sweep_read("R1 readback after writes");

        // R4: both read the same word
        a_en = 1'b1; a_we = 1'b0; a_addr = 10'd100;
        b_en = 1'b1; b_we = 1'b0; b_addr = 10'd100;
        #1;
        chk("R5 match on read-read", int'(match_n), 0);
        tick;
        idle_main;
        chk("R4 a reads shared word", int'(a_rdata), model[100]);
        tick;
        chk("R4 b reads shared word", int'(b_rdata), model[100]);

        // R6: A writes, B reads the same word
        old = model[200];
        nw  = (old + 7) % 16;
        a_en = 1'b1; a_we = 1'b1; a_addr = 10'd200; a_wdata = 4'(nw);
        b_en = 1'b1; b_we = 1'b0; b_addr = 10'd200;
        #1;
        chk("R5 match on write-read", int'(match_n), 0);
        tick;
        model[200] = nw;
        idle_main;
        tick;
        chk("R6 b sees old word first", int'(b_rdata), old);
        tick;
        chk("R6 b then sees new word", int'(b_rdata), nw);

        // R7: A reads, B writes the same word
        old = model[300];
        nw  = (old + 3) % 16;
        a_en = 1'b1; a_we = 1'b0; a_addr = 10'd300;
        b_en = 1'b1; b_we = 1'b1; b_addr = 10'd300; b_wdata = 4'(nw);
        #1;
        chk("R5 match on read-write", int'(match_n), 0);
        tick;
        model[300] = nw;
        idle_main;
        chk("R7 a sees old word first", int'(a_rdata), old);
        tick;
        chk("R7 a then sees new word", int'(a_rdata), nw);

        // R8: both write the same word
        da = (model[400] + 1) % 16;
        db = (model[400] + 2) % 16;
        a_en = 1'b1; a_we = 1'b1; a_addr = 10'd400; a_wdata = 4'(da);
        b_en = 1'b1; b_we = 1'b1; b_addr = 10'd400; b_wdata = 4'(db);
        #1;
        chk("R5 match on write-write", int'(match_n), 0);
        tick;
        idle_main;
        chk("R8 b_busy during deferral", int'(b_busy), 1);
        tick;
        chk("R8 b_busy clears", int'(b_busy), 0);
        a_en = 1'b1; a_we = 1'b0; a_addr = 10'd400;
        tick;
        idle_main;
        model[400] = db;
        chk("R8 final word is B's", int'(a_rdata), db);

        // R8: writes to different words never defer
        a_en = 1'b1; a_we = 1'b1; a_addr = 10'd500; a_wdata = 4'd9;
        b_en = 1'b1; b_we = 1'b1; b_addr = 10'd501; b_wdata = 4'd6;
        #1;
        chk("R5 no match on distinct writes", int'(match_n), 1);
        tick;
        idle_main;
        chk("R8 no busy on distinct writes", int'(b_busy), 0);
        a_en = 1'b1; a_we = 1'b0; a_addr = 10'd500;
        tick;
        chk("R8 distinct write A stored", int'(a_rdata), 9);
        a_addr = 10'd501;
        tick;
        idle_main;
        chk("R8 distinct write B stored", int'(a_rdata), 6);

        // R9: read-only build ignores writes, even colliding ones
        r_a_en = 1'b1; r_a_we = 1'b1; r_a_addr = 11'd5; r_a_wdata = 2'(~init_rom(5));
        r_b_en = 1'b1; r_b_we = 1'b1; r_b_addr = 11'd5; r_b_wdata = 2'(init_rom(5) + 1);
        #1;
        chk("R5 rom match on same word", int'(r_match_n), 0);
        tick;
        r_b_en = 1'b0; r_b_we = 1'b0;
        chk("R9 rom no busy", int'(r_b_busy), 0);
        for (int i = 0; i < RD; i++) begin
            r_a_en = 1'b1; r_a_we = 1'b1; r_a_addr = 11'(i); r_a_wdata = 2'(~init_rom(i));
            tick;
        end
        for (int i = 0; i < RD; i++) begin
            r_a_en = 1'b1; r_a_we = 1'b0; r_a_addr = 11'(i);
            tick;
            chk("R9 rom content unchanged", int'(r_a_rdata), init_rom(i));
        end
        r_a_en = 1'b0;

        // R10: falling-edge output stage on port B
        r_b_en = 1'b1; r_b_we = 1'b0; r_b_addr = 11'd6;
        tick;
        chk("R10 not before falling edge", int'(r_b_rdata), 0);
        #5;
        chk("R10 after falling edge", int'(r_b_rdata), init_rom(6));
        r_b_addr = 11'd9;
        tick;
        chk("R10 second read not before falling edge", int'(r_b_rdata), init_rom(6));
        #5;
        chk("R10 second read after falling edge", int'(r_b_rdata), init_rom(9));
        r_b_en = 1'b0;
        tick;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule